// File: doc/BRIEF.md
# Clock/Calendar I2C Register Target

This block is the two-wire serial front end of a clock/calendar device. It listens on SCL and SDA, samples both lines into a fast system clock domain, and finds the bus conditions: START, repeated START and STOP. It answers one fixed 7-bit device address. A write transfer sets an internal register pointer with its first byte. Each further byte is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the current pointer and advances it after each byte. The block pulls SDA low through a drive-low enable that models an open-drain pin.

The register map has sixteen byte locations. The lower fourteen belong to the timekeeping core. The block reaches them through a simple port: an address, a one-cycle write strobe, write data, and combinational read data. The top two locations are held inside the block. One is a control byte. The other is a status byte, whose flag bits the core can set and software can only clear. Pads, spike filtering and clock stretching sit outside this block.

Top module: `rtc_i2c_target`

## Requirements
- R1: After reset, SDA is released (`sdaDriveLow` = 0). The control byte (index 0Eh) reads 18h and the status byte (index 0Fh) reads 80h.
- R2: An address byte whose upper seven bits equal 1101000b gets an ACK: D0h selects a write and D1h selects a read. Any other address gets no ACK, and the bytes that follow are ignored until the next START.
- R3: In a write transfer, the first byte after the address loads the register pointer. A pointer byte of 10h or more gets no ACK and leaves the pointer unchanged.
- R4: Each later write byte is acknowledged and stored at the pointer. The pointer then advances, wrapping from 0Fh to 00h. Locations 00h–0Dh go out on the core write port as a single-cycle strobe per byte.
- R5: A read transfer returns the byte at the current pointer, even when no pointer byte was sent first. The pointer advances once per byte returned. The byte is captured when its transfer starts.
- R6: The ACK is driven low from the falling SCL edge that ends the 8th bit until the falling edge that ends the 9th. SDA is released after that edge, and the drive level only changes while SCL is low.
- R7: When the master does not acknowledge a read byte, the block stops driving SDA and stays silent until a STOP or a new START, even if SCL keeps toggling.
- R8: A repeated START in the middle of a transfer is accepted and begins a new address byte.
- R9: The alarm flags (status bits 1:0) and the oscillator-stop flag (status bit 7) are cleared only by writing 0 to that bit. Writing 1 leaves a flag unchanged. A set request from the core (`flagSet[i]` to bit i, `oscStopEvt` to bit 7) wins over a clear in the same cycle.
- R10: Bits fixed at zero always read 0: control bits 6:5 and status bits 6:2. A write of FFh to the control byte reads back as 9Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| coreAddr | output | 4 | Register pointer, the core read/write address |
| coreWrEn | output | 1 | One-cycle write strobe for core locations 00h–0Dh |
| coreWrData | output | 8 | Byte to be written into the core |
| coreRdData | input | 8 | Core byte at `coreAddr`, combinational |
| flagSet | input | 2 | Alarm match pulses that set status bits 1:0 |
| oscStopEvt | input | 1 | Oscillator-stop pulse that sets status bit 7 |
| ctrlReg | output | 8 | Current control byte |
| statusReg | output | 8 | Current status byte |

## Verification
Write bursts show that a pointer is taken from the first byte and that data lands at consecutive locations. A burst that crosses 0Fh shows the wrap to 00h. A foreign address and an oversized pointer byte each test the NACK path: nothing is acknowledged and no location changes. Reads are run three ways: after a repeated START, from the pointer left by an earlier transfer, and after a master NACK with extra clocks. Together these separate correct pointer advance from stale or duplicated bytes, and show whether SDA is truly released. Writes of all ones and of mixed patterns to the status byte show the difference between clear-only flags and plainly writable bits.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK_OUT,
    ST_SEND,
    ST_ACK_IN,
    ST_WAIT_STOP
  } busState_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } byteKind_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic incPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  localparam logic [7:0] CTRL_KEEP  = 8'h9F;
  localparam logic [7:0] STAT_KEEP  = 8'h83;
  localparam logic [7:0] CTRL_RESET = 8'h18;
  localparam logic [7:0] STAT_RESET = 8'h80;

endpackage

// File: rtl/rtc_i2c_bus_sync.sv
module rtc_i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  // idle bus is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclSync  = sclPipe[STAGES-1];
  assign sdaSync  = sdaPipe[STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

endmodule

// File: rtl/rtc_i2c_ctrl.sv
module rtc_i2c_ctrl
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         REG_COUNT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaDriveLow
);

  localparam logic [8:0] REG_LIMIT = 9'(REG_COUNT);

  busState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic       isRead;
  logic       masterAck;

  logic addrOk;
  logic ptrOk;
  logic byteEnd;

  assign addrOk  = (rxByte[7:1] == DEV_ADDR);
  assign ptrOk   = ({1'b0, rxByte} < REG_LIMIT);
  assign byteEnd = sclFall && (bitCnt == 4'd8);

  always_comb begin
    strobe = '0;
    if (!startDet && !stopDet) begin
      case (state)
        ST_RECV: begin
          strobe.shiftRx = sclRise && (bitCnt < 4'd8);
          if (byteEnd && kind == BY_PTR && ptrOk) strobe.loadPtr = 1'b1;
          if (byteEnd && kind == BY_DATA) begin
            strobe.writeReg = 1'b1;
            strobe.incPtr   = 1'b1;
          end
        end
        ST_ACK_OUT: begin
          if (sclFall && kind == BY_ADDR && isRead) begin
            strobe.loadTx = 1'b1;
            strobe.incPtr = 1'b1;
          end
        end
        ST_SEND: begin
          strobe.shiftTx = sclFall && (bitCnt != 4'd7);
        end
        ST_ACK_IN: begin
          if (sclFall && masterAck) begin
            strobe.loadTx = 1'b1;
            strobe.incPtr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= BY_ADDR;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RECV;
      kind   <= BY_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            case (kind)
              BY_ADDR: begin
                if (addrOk) begin
                  isRead <= rxByte[0];
                  state  <= ST_ACK_OUT;
                end else begin
                  state <= ST_WAIT_STOP;
                end
              end
              BY_PTR:  state <= ptrOk ? ST_ACK_OUT : ST_WAIT_STOP;
              default: state <= ST_ACK_OUT;
            endcase
          end
        end
        ST_ACK_OUT: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == BY_ADDR && isRead) begin
              state <= ST_SEND;
            end else begin
              state <= ST_RECV;
              kind  <= (kind == BY_ADDR) ? BY_PTR : BY_DATA;
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_ACK_IN;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_ACK_IN: begin
          if (sclRise) masterAck <= ~sdaSync;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_SEND : ST_WAIT_STOP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ACK_OUT) || (state == ST_SEND && !txBit);

endmodule

// File: rtl/rtc_i2c_dp.sv
module rtc_i2c_dp
  import rtc_i2c_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int PTR_W     = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             sdaSync,
  input  logic [7:0]       coreRdData,
  input  logic [1:0]       flagSet,
  input  logic             oscStopEvt,
  output logic [7:0]       rxByte,
  output logic             txBit,
  output logic [PTR_W-1:0] coreAddr,
  output logic             coreWrEn,
  output logic [7:0]       coreWrData,
  output logic [7:0]       ctrlReg,
  output logic [7:0]       statusReg
);

  localparam logic [PTR_W-1:0] CTRL_IDX = PTR_W'(REG_COUNT - 2);
  localparam logic [PTR_W-1:0] STAT_IDX = PTR_W'(REG_COUNT - 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(REG_COUNT - 1);

  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       readMux;
  logic [7:0]       statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strobe.shiftRx) rxShift <= {rxShift[6:0], sdaSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= rxShift[PTR_W-1:0];
    end else if (strobe.incPtr) begin
      ptr <= (ptr == LAST_IDX) ? '0 : ptr + PTR_W'(1);
    end
  end

  always_comb begin
    if (ptr == CTRL_IDX)      readMux = ctrlReg;
    else if (ptr == STAT_IDX) readMux = statusReg;
    else                      readMux = coreRdData;
  end

  // the byte is frozen at load so core updates cannot tear it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (strobe.loadTx) txShift <= readMux;
    else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= CTRL_RESET;
    else if (strobe.writeReg && ptr == CTRL_IDX) ctrlReg <= rxShift & CTRL_KEEP;
  end

  always_comb begin
    statusNext = statusReg;
    if (strobe.writeReg && ptr == STAT_IDX) begin
      statusNext[7]   = statusReg[7] & rxShift[7];
      statusNext[1:0] = statusReg[1:0] & rxShift[1:0];
    end
    statusNext[1:0] = statusNext[1:0] | flagSet;
    statusNext[7]   = statusNext[7] | oscStopEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= STAT_RESET;
    else statusReg <= statusNext & STAT_KEEP;
  end

  assign rxByte     = rxShift;
  assign txBit      = txShift[7];
  assign coreAddr   = ptr;
  assign coreWrData = rxShift;
  assign coreWrEn   = strobe.writeReg && (ptr < CTRL_IDX);

endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         REG_COUNT   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow,
  output logic [PTR_W-1:0] coreAddr,
  output logic             coreWrEn,
  output logic [7:0]       coreWrData,
  input  logic [7:0]       coreRdData,
  input  logic [1:0]       flagSet,
  input  logic             oscStopEvt,
  output logic [7:0]       ctrlReg,
  output logic [7:0]       statusReg
);

  logic      sclSync;
  logic      sdaSync;
  logic      sclRise;
  logic      sclFall;
  logic      startDet;
  logic      stopDet;
  logic [7:0] rxByte;
  logic      txBit;
  dpStrobe_t strobe;

  rtc_i2c_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  rtc_i2c_ctrl #(.DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaSync(sdaSync),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  rtc_i2c_dp #(.REG_COUNT(REG_COUNT), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaSync(sdaSync),
    .coreRdData(coreRdData), .flagSet(flagSet), .oscStopEvt(oscStopEvt),
    .rxByte(rxByte), .txBit(txBit), .coreAddr(coreAddr),
    .coreWrEn(coreWrEn), .coreWrData(coreWrData),
    .ctrlReg(ctrlReg), .statusReg(statusReg)
  );

endmodule

// File: rtl/rtc_i2c_chk.sv
module rtc_i2c_chk
  import rtc_i2c_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclSync,
  input logic       sdaDriveLow,
  input logic       coreWrEn,
  input logic [1:0] flagSet,
  input logic       oscStopEvt,
  input logic [7:0] ctrlReg,
  input logic [7:0] statusReg
);

  // R10
  fixed_zero_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~CTRL_KEEP) == 8'h00);

  // R10
  fixed_zero_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~STAT_KEEP) == 8'h00);

  // R9
  alarm0_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[0] |=> statusReg[0]);

  // R9
  alarm1_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[1] |=> statusReg[1]);

  // R9
  osc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscStopEvt |=> statusReg[7]);

  // R9
  alarm0_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> $past(flagSet[0]));

  // R6
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclSync);

  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWrEn |=> !coreWrEn);

endmodule

bind rtc_i2c_target rtc_i2c_chk chk_i (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaDriveLow(sdaDriveLow),
  .coreWrEn(coreWrEn), .flagSet(flagSet), .oscStopEvt(oscStopEvt),
  .ctrlReg(ctrlReg), .statusReg(statusReg)
);

// File: tb/rtc_i2c_target_tb.sv
`timescale 1ns/1ps
module rtc_i2c_target_tb_top;

  localparam int Q = 200;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sclM;
  logic       sdaM;
  logic       sdaDriveLow;
  logic [3:0] coreAddr;
  logic       coreWrEn;
  logic [7:0] coreWrData;
  logic [7:0] coreRdData;
  logic [1:0] flagSet;
  logic       oscStopEvt;
  logic [7:0] ctrlReg;
  logic [7:0] statusReg;
  logic [7:0] coreMem [16];
  logic       sdaLine;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign sdaLine    = sdaM & ~sdaDriveLow;
  assign coreRdData = coreMem[coreAddr];

  always @(posedge clk) if (coreWrEn) coreMem[coreAddr] <= coreWrData;

  rtc_i2c_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .coreAddr(coreAddr), .coreWrEn(coreWrEn),
    .coreWrData(coreWrData), .coreRdData(coreRdData), .flagSet(flagSet),
    .oscStopEvt(oscStopEvt), .ctrlReg(ctrlReg), .statusReg(statusReg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q; sdaM = 1'b0; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic busStop();
    sdaM = 1'b0; #Q; sclM = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked, output logic released);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #Q; sclM = 1'b1; #(2*Q); sclM = 1'b0; #Q;
    end
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q;
    acked = ~sdaLine;
    #Q; sclM = 1'b0; #Q;
    released = ~sdaDriveLow;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; sclM = 1'b1; #Q; b[i] = sdaLine; #Q; sclM = 1'b0;
    end
    sdaM = ~giveAck; #Q; sclM = 1'b1; #(2*Q); sclM = 1'b0; #Q; sdaM = 1'b1;
  endtask

  task automatic writeRegs(input logic [7:0] ptrByte, input logic [7:0] d0,
                           input logic [7:0] d1, input int n, input string tag);
    logic a, r;
    busStart();
    sendByte(8'hD0, a, r); check({tag, " addr ack"}, {7'd0, a}, 8'd1);
    sendByte(ptrByte, a, r); check({tag, " ptr ack"}, {7'd0, a}, 8'd1);
    if (n > 0) begin sendByte(d0, a, r); check({tag, " data ack"}, {7'd0, a}, 8'd1); end
    if (n > 1) begin sendByte(d1, a, r); check({tag, " data ack"}, {7'd0, a}, 8'd1); end
    busStop();
  endtask

  task automatic testReset();
    check("R1 drive released", {7'd0, sdaDriveLow}, 8'd0);
    check("R1 control default", ctrlReg, 8'h18);
    check("R1 status default", statusReg, 8'h80);
  endtask

  task automatic testWriteBurst();
    logic a, r;
    busStart();
    sendByte(8'hD0, a, r); check("R2 D0h acked", {7'd0, a}, 8'd1);
    sendByte(8'h02, a, r); check("R3 pointer acked", {7'd0, a}, 8'd1);
    check("R6 released after 9th", {7'd0, r}, 8'd1);
    sendByte(8'hA1, a, r); check("R4 data acked", {7'd0, a}, 8'd1);
    sendByte(8'hB2, a, r);
    sendByte(8'hC3, a, r); check("R6 released after data ack", {7'd0, r}, 8'd1);
    busStop();
    check("R4 loc 02", coreMem[2], 8'hA1);
    check("R4 loc 03", coreMem[3], 8'hB2);
    check("R4 loc 04", coreMem[4], 8'hC3);
  endtask

  task automatic testWrongAddr();
    logic a, r;
    busStart();
    sendByte(8'hA0, a, r); check("R2 foreign address nack", {7'd0, a}, 8'd0);
    sendByte(8'h02, a, r); check("R2 ignored byte nack", {7'd0, a}, 8'd0);
    sendByte(8'h55, a, r);
    busStop();
    check("R2 loc 02 untouched", coreMem[2], 8'hA1);
  endtask

  task automatic testReadRestart();
    logic a, r;
    logic [7:0] d;
    busStart();
    sendByte(8'hD0, a, r);
    sendByte(8'h02, a, r);
    busStart();
    sendByte(8'hD1, a, r); check("R8 D1h acked after restart", {7'd0, a}, 8'd1);
    recvByte(1'b1, d); check("R5 read loc 02", d, 8'hA1);
    recvByte(1'b1, d); check("R5 read loc 03", d, 8'hB2);
    recvByte(1'b0, d); check("R5 read loc 04", d, 8'hC3);
    #Q; check("R7 released after nack", {7'd0, sdaDriveLow}, 8'd0);
    recvByte(1'b0, d); check("R7 silent after nack", d, 8'hFF);
    busStop();
  endtask

  task automatic testBadPointer();
    logic a, r;
    logic [7:0] d;
    busStart();
    sendByte(8'hD0, a, r);
    sendByte(8'h20, a, r); check("R3 oversized pointer nack", {7'd0, a}, 8'd0);
    busStop();
    busStart();
    sendByte(8'hD1, a, r);
    recvByte(1'b0, d); check("R3 pointer kept, R5 current read", d, 8'h15);
    busStop();
    busStart();
    sendByte(8'hD1, a, r);
    recvByte(1'b1, d); check("R5 pointer advanced", d, 8'h16);
    recvByte(1'b0, d); check("R5 pointer advanced again", d, 8'h17);
    busStop();
  endtask

  task automatic testWrapAndControl();
    logic a, r;
    busStart();
    sendByte(8'hD0, a, r);
    sendByte(8'h0E, a, r);
    sendByte(8'hFF, a, r);
    sendByte(8'h7E, a, r);
    sendByte(8'h5A, a, r); check("R4 wrapped byte acked", {7'd0, a}, 8'd1);
    busStop();
    check("R10 control FFh reads 9Fh", ctrlReg, 8'h9F);
    check("R9 oscillator flag cleared by 0", statusReg, 8'h00);
    check("R4 wrap to loc 00", coreMem[0], 8'h5A);
  endtask

  task automatic testFlags();
    logic [7:0] d;
    logic a, r;
    @(negedge clk); flagSet = 2'b11;
    @(negedge clk); flagSet = 2'b00;
    check("R9 alarm flags set", statusReg, 8'h03);
    oscStopEvt = 1'b1;
    @(negedge clk); oscStopEvt = 1'b0;
    check("R9 oscillator flag set", statusReg, 8'h83);
    writeRegs(8'h0F, 8'hFF, 8'h00, 1, "R9 write ones");
    check("R9 ones leave flags", statusReg, 8'h83);
    writeRegs(8'h0F, 8'h7E, 8'h00, 1, "R9 write mixed");
    check("R9 zeros clear bits 7 and 0", statusReg, 8'h02);
    busStart();
    sendByte(8'hD0, a, r);
    sendByte(8'h0E, a, r);
    busStart();
    sendByte(8'hD1, a, r);
    recvByte(1'b1, d); check("R10 control read over bus", d, 8'h9F);
    recvByte(1'b0, d); check("R9 status read over bus", d, 8'h02);
    busStop();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) coreMem[i] = 8'h10 + 8'(i);
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; flagSet = 2'b00; oscStopEvt = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWriteBurst();
    testWrongAddr();
    testReadRestart();
    testBadPointer();
    testWrapAndControl();
    testFlags();
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule